// File: doc/BRIEF.md
# Line-Tagged Shared Receive Silo

This block collects received characters from up to eight serial lines into one first-in first-out store, so the host services every line through a single read port. Each stored entry carries the number of the line it came from, the character, and per-character parity and framing error flags. A change of modem signals on a line is stored the same way, as an in-band marker entry with no character. A single lost-data flag is carried forward to the next entry that gets stored. The deserializers in front of the block are modelled as plain valid/data strobes. The host reads a 16-bit word: the top bit says whether the word holds an entry, and any read of a valid word removes that entry.

Every line has a small holding stage, a state machine with the states HOLD_IDLE (nothing held), HOLD_CHAR (one character held), HOLD_EVENT (a modem-change marker pending) and HOLD_BOTH (both held). An arrival moves the stage up: IDLE→CHAR, IDLE→EVENT, CHAR→BOTH, EVENT→BOTH. A grant moves it down: EVENT→IDLE, BOTH→CHAR, CHAR→IDLE. When a grant and an arrival fall in the same cycle, the stage keeps or reloads the item in that cycle. A round-robin arbiter takes one holding stage per cycle into the silo. The silo has its own state machine with the states SILO_EMPTY, SILO_PARTIAL and SILO_FULL. The first store moves EMPTY→PARTIAL. A store that reaches the depth moves PARTIAL→FULL. A read that frees a slot moves FULL→PARTIAL. A read of the last entry moves PARTIAL→EMPTY.

Top module: `rx_silo_top`

## Requirements
- R1: `rd_word` bit 15 is 1 exactly when the silo holds an entry. With the silo empty, `rd_word` is 16'h0000, and a read strobe changes nothing: the next entry stored is the next one read.
- R2: A character entry reads as bit 15 = 1, bits 10:8 = source line, bits 7:0 = character, bit 12 = parity error flag, bit 13 = framing (break) error flag, bit 11 = 0.
- R3: A modem-change entry has bit 11 = 1, bits 10:8 = line, and bits 7:0, 12 and 13 all zero.
- R4: Entries leave in the order in which they were stored. Each read strobe on a valid word removes the head entry.
- R5: When several lines have entries held at once, one line is stored per cycle. The search starts at the line after the one granted last, wrapping around. After reset the search starts at line 0.
- R6: If a line has both a modem-change marker and a character held, the marker is stored first.
- R7: A character that arrives while its line's holding stage still holds an unstored character is dropped. The next entry stored after the drop has bit 14 (overrun) set. Entries stored after that one have bit 14 clear until another drop occurs.
- R8: `rx_irq` is 1 exactly when `rie` is 1 and the silo is non-empty.
- R9: With no contention, a strobe sampled at clock edge k is readable right after edge k+1 and not before.
- R10: The silo holds DEPTH entries. When full it stores nothing more until a read frees a slot, and meanwhile each line keeps one item in its holding stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | NUM_LINES | Per-line character strobe |
| line_data | input | 8*NUM_LINES | Per-line character, line i in bits 8i+7:8i |
| line_perr | input | NUM_LINES | Per-line parity error with the strobe |
| line_ferr | input | NUM_LINES | Per-line framing error with the strobe |
| line_mchg | input | NUM_LINES | Per-line modem-signal change pulse |
| rd_en | input | 1 | Host read strobe; removes the head entry |
| rie | input | 1 | Receive interrupt enable |
| rd_word | output | 16 | Head entry with valid bit 15 |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with all eight lines and DEPTH set to 8. With that depth, a few strobes fill the silo, so the full state, held items on a full silo, dropped characters and the overrun mark on the next stored entry are all reached quickly. With eight lines, the bench can strobe every line at once to check the wrap-around arbiter order. It can also check the start of the next search after a single grant.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

    localparam int ENTRY_W = 15;

    typedef struct packed {
        logic       ovr;
        logic       ferr;
        logic       perr;
        logic       mchg;
        logic [2:0] line;
        logic [7:0] chr;
    } silo_entry_t;

    typedef enum logic [1:0] {
        HOLD_IDLE,
        HOLD_CHAR,
        HOLD_EVENT,
        HOLD_BOTH
    } hold_state_t;

    typedef enum logic [1:0] {
        SILO_EMPTY,
        SILO_PARTIAL,
        SILO_FULL
    } silo_state_t;

endpackage

// File: rtl/rx_line_hold.sv
module rx_line_hold
    import rx_silo_pkg::*;
#(
    parameter int LINE_ID = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_chr,
    input  logic        in_perr,
    input  logic        in_ferr,
    input  logic        in_mchg,
    input  logic        grant,
    output logic        req,
    output silo_entry_t out_entry,
    output logic        drop
);

    hold_state_t state_q, state_d;
    logic [7:0]  chr_q;
    logic        perr_q, ferr_q;
    logic        has_chr, has_evt, serve_evt, serve_chr, take_chr;
    logic        chr_next, evt_next;

    always_comb begin
        has_chr   = (state_q == HOLD_CHAR) || (state_q == HOLD_BOTH);
        has_evt   = (state_q == HOLD_EVENT) || (state_q == HOLD_BOTH);
        serve_evt = grant && has_evt;
        serve_chr = grant && !has_evt && has_chr;
        take_chr  = in_valid && (!has_chr || serve_chr);
        chr_next  = (has_chr && !serve_chr) || take_chr;
        evt_next  = (has_evt && !serve_evt) || in_mchg;
        unique case ({chr_next, evt_next})
            2'b00:   state_d = HOLD_IDLE;
            2'b10:   state_d = HOLD_CHAR;
            2'b01:   state_d = HOLD_EVENT;
            default: state_d = HOLD_BOTH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOLD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chr_q  <= '0;
            perr_q <= 1'b0;
            ferr_q <= 1'b0;
        end else if (take_chr) begin
            chr_q  <= in_chr;
            perr_q <= in_perr;
            ferr_q <= in_ferr;
        end
    end

    always_comb begin
        req            = has_chr || has_evt;
        drop           = in_valid && has_chr && !serve_chr;
        out_entry.ovr  = 1'b0;
        out_entry.line = 3'(LINE_ID);
        out_entry.mchg = has_evt;
        out_entry.chr  = has_evt ? 8'h00 : chr_q;
        out_entry.perr = has_evt ? 1'b0 : perr_q;
        out_entry.ferr = has_evt ? 1'b0 : ferr_q;
    end

    // R5: arbiter never grants an empty holding stage
    assert_grant_has_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req);

    // R7: a dropped arrival leaves the held character in place
    assert_drop_keeps_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> (state_q == HOLD_CHAR || state_q == HOLD_BOTH));

endmodule

// File: rtl/rx_rr_arb.sv
module rx_rr_arb #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             en,
    output logic [N-1:0]     grant,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx
);

    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] cand;

    always_comb begin
        grant     = '0;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        cand      = '0;
        for (int k = 1; k <= N; k++) begin
            cand = IDX_W'((int'(last_q) + k) % N);
            if (!gnt_valid && en && req[cand]) begin
                gnt_valid   = 1'b1;
                grant[cand] = 1'b1;
                gnt_idx     = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IDX_W'(N - 1);
        end else if (gnt_valid) begin
            last_q <= gnt_idx;
        end
    end

endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo
    import rx_silo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  silo_entry_t push_entry,
    input  logic        pop,
    output silo_entry_t head_entry,
    output logic        empty,
    output logic        full
);

    silo_entry_t mem [DEPTH];
    silo_state_t state_q, state_d;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (state_q != SILO_FULL);
        do_pop  = pop && (state_q != SILO_EMPTY);
        state_d = state_q;
        unique case (state_q)
            SILO_EMPTY: begin
                if (do_push) state_d = (DEPTH == 1) ? SILO_FULL : SILO_PARTIAL;
            end
            SILO_PARTIAL: begin
                if (do_push && !do_pop && cnt_q == CNT_W'(DEPTH - 1))
                    state_d = SILO_FULL;
                else if (do_pop && !do_push && cnt_q == CNT_W'(1))
                    state_d = SILO_EMPTY;
            end
            SILO_FULL: begin
                if (do_pop) state_d = (DEPTH == 1) ? SILO_EMPTY : SILO_PARTIAL;
            end
            default: state_d = SILO_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SILO_EMPTY;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_entry;
    end

    always_comb begin
        empty      = (state_q == SILO_EMPTY);
        full       = (state_q == SILO_FULL);
        head_entry = mem[rd_ptr];
    end

    // R10: the arbiter never offers an entry to a full silo
    assert_no_push_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (state_q != SILO_FULL));

    // R10: the full state agrees with the occupancy count
    assert_full_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SILO_FULL) |-> (cnt_q == CNT_W'(DEPTH)));

    // R1: a read of an empty silo leaves it empty and the pointers still
    assert_empty_read_inert_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && state_q == SILO_EMPTY && !push) |=>
            (state_q == SILO_EMPTY && $stable(rd_ptr) && $stable(wr_ptr)));

endmodule

// File: rtl/rx_silo_top.sv
module rx_silo_top
    import rx_silo_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int DEPTH     = 64,
    localparam int CHR_W    = 8,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LINES-1:0]       line_valid,
    input  logic [CHR_W*NUM_LINES-1:0] line_data,
    input  logic [NUM_LINES-1:0]       line_perr,
    input  logic [NUM_LINES-1:0]       line_ferr,
    input  logic [NUM_LINES-1:0]       line_mchg,
    input  logic                       rd_en,
    input  logic                       rie,
    output logic [15:0]                rd_word,
    output logic                       rx_irq
);

    silo_entry_t            hold_entry [NUM_LINES];
    logic [NUM_LINES-1:0]   hold_req, hold_drop, grant;
    logic                   gnt_valid, silo_empty, silo_full, ovr_q, drop_any;
    logic [IDX_W-1:0]       gnt_idx;
    silo_entry_t            push_entry, head_entry;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        rx_line_hold #(.LINE_ID(i)) u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (line_valid[i]),
            .in_chr    (line_data[i*CHR_W +: CHR_W]),
            .in_perr   (line_perr[i]),
            .in_ferr   (line_ferr[i]),
            .in_mchg   (line_mchg[i]),
            .grant     (grant[i]),
            .req       (hold_req[i]),
            .out_entry (hold_entry[i]),
            .drop      (hold_drop[i])
        );
    end

    rx_rr_arb #(.N(NUM_LINES)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (hold_req),
        .en        (!silo_full),
        .grant     (grant),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx)
    );

    always_comb begin
        push_entry     = hold_entry[gnt_idx];
        push_entry.ovr = ovr_q;
        drop_any       = |hold_drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= drop_any || (ovr_q && !gnt_valid);
        end
    end

    rx_silo_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (gnt_valid),
        .push_entry (push_entry),
        .pop        (rd_en),
        .head_entry (head_entry),
        .empty      (silo_empty),
        .full       (silo_full)
    );

    always_comb begin
        rd_word = silo_empty ? 16'h0000 : {1'b1, head_entry};
        rx_irq  = rie && !silo_empty;
    end

    // R8: interrupt follows enable and the valid bit of the read port
    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq == (rie && rd_word[15]));

    // R7: the overrun mark is consumed by the entry that carries it
    assert_ovr_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && ovr_q && !drop_any) |=> !ovr_q);

endmodule

// File: tb/rx_silo_top_test.sv
module rx_silo_top_test;

    localparam int NL  = 8;
    localparam int DEP = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NL-1:0]     line_valid, line_perr, line_ferr, line_mchg;
    logic [8*NL-1:0]   line_data;
    logic              rd_en, rie;
    logic [15:0]       rd_word;
    logic              rx_irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] model_q [$];

    always #4 clk = ~clk;

    rx_silo_top #(.NUM_LINES(NL), .DEPTH(DEP)) uut (
        .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_data(line_data),
        .line_perr(line_perr), .line_ferr(line_ferr), .line_mchg(line_mchg),
        .rd_en(rd_en), .rie(rie), .rd_word(rd_word), .rx_irq(rx_irq)
    );

    function automatic logic [15:0] exp_word(int line, logic [7:0] chr, logic pe,
                                             logic fe, logic mc, logic ov);
        if (mc) return {1'b1, ov, 1'b0, 1'b0, 1'b1, 3'(line), 8'h00};
        return {1'b1, ov, fe, pe, 1'b0, 3'(line), chr};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        line_valid = '0; line_perr = '0; line_ferr = '0; line_mchg = '0;
        line_data = '0;
    endtask

    task automatic set_line(int line, logic [7:0] chr, logic pe, logic fe, logic mc);
        if (mc) begin
            line_mchg[line] = 1'b1;
        end else begin
            line_valid[line] = 1'b1;
            line_data[line*8 +: 8] = chr;
            line_perr[line] = pe;
            line_ferr[line] = fe;
        end
    endtask

    // called at a falling edge; returns with the item readable
    task automatic send(int line, logic [7:0] chr, logic pe, logic fe, logic mc);
        set_line(line, chr, pe, fe, mc);
        @(negedge clk);
        clear_inputs();
        @(negedge clk);
    endtask

    task automatic read_word(output logic [15:0] w);
        w = rd_word;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'h00C0FFEE));
        rst_n = 1'b0; rd_en = 1'b0; rie = 1'b1;
        clear_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R1 reset word", rd_word, 16'h0000);
        chk("R8 reset irq", {15'b0, rx_irq}, 16'h0000);

        // read of empty silo returns zero and changes nothing
        read_word(w);
        chk("R1 empty read", w, 16'h0000);

        // all lines at once: order from line 0 after reset
        for (int i = 0; i < NL; i++) set_line(i, 8'(8'h10 + i), 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        clear_inputs();
        repeat (9) @(negedge clk);
        for (int i = 0; i < NL; i++) begin
            read_word(w);
            chk("R5 all-line order", w, exp_word(i, 8'(8'h10 + i), 1'b0, 1'b0, 1'b0, 1'b0));
        end
        read_word(w);
        chk("R1 empty after drain", w, 16'h0000);

        // latency and field encoding
        set_line(5, 8'hA5, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        clear_inputs();
        chk("R9 not yet visible", rd_word, 16'h0000);
        @(negedge clk);
        chk("R9 visible after second edge", rd_word, exp_word(5, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0));
        chk("R8 irq enabled", {15'b0, rx_irq}, 16'h0001);
        rie = 1'b0;
        #1;
        chk("R8 irq masked", {15'b0, rx_irq}, 16'h0000);
        rie = 1'b1;
        read_word(w);
        chk("R2 parity char", w, exp_word(5, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0));
        send(7, 8'h3C, 1'b0, 1'b1, 1'b0);
        read_word(w);
        chk("R2 framing char", w, exp_word(7, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0));

        // modem change marker
        send(3, 8'h00, 1'b0, 1'b0, 1'b1);
        read_word(w);
        chk("R3 modem marker", w, 16'h8B00);

        // rotation: last grant line 4, then lines 1 and 6 together -> 6 first
        send(4, 8'h44, 1'b0, 1'b0, 1'b0);
        read_word(w);
        chk("R5 single line 4", w, exp_word(4, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0));
        set_line(1, 8'h11, 1'b0, 1'b0, 1'b0);
        set_line(6, 8'h66, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        clear_inputs();
        repeat (2) @(negedge clk);
        read_word(w);
        chk("R5 rotation first", w, exp_word(6, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0));
        read_word(w);
        chk("R5 rotation second", w, exp_word(1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0));

        // marker and character on one line together: marker first
        set_line(2, 8'h22, 1'b0, 1'b0, 1'b0);
        set_line(2, 8'h00, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        clear_inputs();
        repeat (2) @(negedge clk);
        read_word(w);
        chk("R6 marker first", w, exp_word(2, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0));
        read_word(w);
        chk("R6 char second", w, exp_word(2, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0));

        // fill, hold, drop, overrun mark
        for (int i = 0; i < DEP; i++) send(0, 8'(8'h40 + i), 1'b0, 1'b0, 1'b0);
        send(1, 8'h77, 1'b0, 1'b0, 1'b0);
        chk("R10 head kept while full", rd_word, exp_word(0, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0));
        send(1, 8'h88, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < DEP; i++) begin
            read_word(w);
            chk("R10 stored entries", w, exp_word(0, 8'(8'h40 + i), 1'b0, 1'b0, 1'b0, 1'b0));
        end
        read_word(w);
        chk("R7 overrun on next entry", w, exp_word(1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b1));
        read_word(w);
        chk("R7 dropped char absent", w, 16'h0000);
        send(3, 8'h5A, 1'b0, 1'b0, 1'b0);
        read_word(w);
        chk("R7 overrun cleared", w, exp_word(3, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0));

        // random single-line traffic against a queue model
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom_range(0, 2));
            rie = 1'($urandom_range(0, 1));
            #1;
            chk("R8 random irq", {15'b0, rx_irq}, {15'b0, rie && (model_q.size() > 0)});
            if (op != 0 && model_q.size() < DEP) begin
                int ln;
                logic [7:0] c;
                logic pe, fe, mc;
                ln = int'($urandom_range(0, NL - 1));
                c  = 8'($urandom_range(0, 255));
                pe = 1'($urandom_range(0, 1));
                fe = 1'($urandom_range(0, 1));
                mc = ($urandom_range(0, 3) == 0);
                send(ln, c, pe, fe, mc);
                model_q.push_back(exp_word(ln, c, pe, fe, mc, 1'b0));
            end else begin
                logic [15:0] e;
                e = (model_q.size() > 0) ? model_q.pop_front() : 16'h0000;
                read_word(w);
                chk("R4 random order", w, e);
            end
        end
        while (model_q.size() > 0) begin
            logic [15:0] e;
            e = model_q.pop_front();
            read_word(w);
            chk("R4 final drain", w, e);
        end
        read_word(w);
        chk("R1 final empty", w, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule